// File: doc/BRIEF.md
# Framer Time-Slot Loopback Selector

This block sits between the receive and transmit halves of a channelized E1/T1 framer. It steers octet-wide time-slot data among four streams. Two streams come in: octets received from the line, and octets the system wants transmitted. Two streams go out: octets sent to the line, and octets delivered to the system. All four streams share one slot index and one frame-start strobe. An 8-bit control word selects a loopback mode and addresses one time slot. The modes are plain pass-through, whole-stream line and board loopbacks, single-slot loopbacks that put an idle code into the vacated slot, a copy of one slot into time slot 0, and payload loopback. In payload loopback, time slot 0 is taken from an external regenerated-framing input.

Configuration takes effect only at a frame boundary, so a frame never carries mixed routing. Every output, including the slot index and the frame strobe, is registered once. All paths therefore share exactly one octet of latency.

Top module: `slot_loop_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero. After reset the active mode is 000 (pass-through) until a control word is accepted at a frame start.
- R2: Mode 000 (control bits 7..5) gives `line_tx_o` = `sys_tx_i` and `sys_rx_o` = `line_rx_i`. `slot_idx_o` and `frame_start_o` follow their inputs. Every output appears exactly one clock after its input octet.
- R3: Modes 001 and 111 give `line_tx_o` = `line_rx_i` in every slot, including slot 0. `sys_rx_o` keeps carrying `line_rx_i`.
- R4: Mode 010 gives `sys_rx_o` = `sys_tx_i`, and `line_tx_o` = 8'hFF (AIS) in every slot.
- R5: Mode 011 applies only in the addressed slot (control bits 4..0). There, `sys_rx_o` = `sys_tx_i` and `line_tx_o` = the idle code. All other slots pass through as in R2.
- R6: Mode 100 applies only in the addressed slot. There, `line_tx_o` = `line_rx_i` and `sys_rx_o` = the idle code. All other slots pass through.
- R7: Mode 101 sends `sys_tx_i` to the line normally. In addition, slot 0 of `line_tx_o` carries the system octet from the addressed slot of the previous frame (zero before any capture since reset).
- R8: Mode 110 with `alt_sel_i` = 0: slot 0 of `line_tx_o` is `regen_i`, and every other slot is `line_rx_i`. `sys_rx_o` keeps carrying `line_rx_i`.
- R9: Mode 110 with `alt_sel_i` = 1: slot 0 of `sys_rx_o` carries the system octet from the addressed slot of the previous frame. Everything else passes through.
- R10: `ctrl_i` and `alt_sel_i` are sampled only in a cycle with `frame_start_i` high. That sample governs the octet of the same cycle and all octets up to the next frame start. Changes in other cycles have no effect.
- R11: With `narrow_i` = 1 (24 slots), an address of 24..31 never matches. Modes 011 and 100 then pass all slots through. Modes 101 and 110 (`alt_sel_i` = 1) leave slot 0 unmodified.
- R12: The idle code is taken from `idle_code_i` in the same cycle as the octet it replaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | High with the slot-0 octet of each frame |
| slot_idx_i | input | 5 | Slot index shared by the input streams |
| narrow_i | input | 1 | 1 = 24-slot frames, 0 = 32-slot frames |
| ctrl_i | input | 8 | Bits 7..5 loopback mode, bits 4..0 slot address |
| alt_sel_i | input | 1 | Mode 110 variant: 0 payload line loop, 1 slot-0 system copy |
| idle_code_i | input | 8 | Fill octet for vacated slots |
| regen_i | input | 8 | Regenerated framing octet for slot 0 |
| line_rx_i | input | 8 | Octet received from the line |
| sys_tx_i | input | 8 | Octet from the system for transmission |
| line_tx_o | output | 8 | Octet sent to the line |
| sys_rx_o | output | 8 | Octet delivered to the system |
| slot_idx_o | output | 5 | Slot index aligned with the outputs |
| frame_start_o | output | 1 | Frame strobe aligned with the outputs |

## Verification
Every mode is driven with random octets on all data inputs. Each output slot therefore names its source uniquely: line receive, system transmit, idle code, regenerated framing, AIS or a captured octet. Directed frames place the address at slot 0, at the last slot, and just beyond the 24-slot range, to separate matching from non-matching. Random control words that change in mid-frame show whether anything other than the frame start updates the routing. Back-to-back frames in the copy modes show that slot 0 takes the octet captured in the previous frame.

// File: rtl/slot_loop_pkg.sv
// Package: shared loopback mode encoding for the slot loop router.
// Assumes the mode sits in the top three bits of the control word.
package slot_loop_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        LB_NONE      = 3'd0,
        LB_LINE      = 3'd1,
        LB_BOARD     = 3'd2,
        LB_SYS_SLOT  = 3'd3,
        LB_LINE_SLOT = 3'd4,
        LB_BCAST     = 3'd5,
        LB_PAYLOAD   = 3'd6,
        LB_FULL_LINE = 3'd7
    } lb_mode_e;
endpackage

// File: rtl/slot_cfg_latch.sv
// Module: slot_cfg_latch
// Holds the active loopback configuration. A new control word is accepted
// only with the frame strobe and applies from that same octet onward.
// Assumes the frame strobe marks slot 0.
module slot_cfg_latch
    import slot_loop_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic [SLOT_W+2:0] ctrl_i,
    input  logic              alt_sel_i,
    output lb_mode_e          mode_o,
    output logic [SLOT_W-1:0] addr_o,
    output logic              alt_o
);
    localparam int CTRL_W = SLOT_W + MODE_W;

    lb_mode_e          mode_q;
    logic [SLOT_W-1:0] addr_q;
    logic              alt_q;

    // Store the configuration seen at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LB_NONE;
            addr_q <= '0;
            alt_q  <= 1'b0;
        end else if (frame_start_i) begin
            mode_q <= lb_mode_e'(ctrl_i[CTRL_W-1 -: MODE_W]);
            addr_q <= ctrl_i[SLOT_W-1:0];
            alt_q  <= alt_sel_i;
        end
    end

    // Present the fresh word during the strobe cycle, the held one otherwise.
    always_comb begin
        if (frame_start_i) begin
            mode_o = lb_mode_e'(ctrl_i[CTRL_W-1 -: MODE_W]);
            addr_o = ctrl_i[SLOT_W-1:0];
            alt_o  = alt_sel_i;
        end else begin
            mode_o = mode_q;
            addr_o = addr_q;
            alt_o  = alt_q;
        end
    end

    // R10: without a frame strobe the held configuration never moves.
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> ($stable(mode_q) && $stable(addr_q) && $stable(alt_q)));
endmodule

// File: rtl/slot_capture.sv
// Module: slot_capture
// Keeps the system octet seen in the addressed slot so that slot 0 of the
// following frame can carry it. Assumes hit_i is high at most once per frame.
module slot_capture #(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [OCT_W-1:0] data_i,
    output logic [OCT_W-1:0] cap_o
);
    // Load the octet whenever the addressed slot passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_o <= '0;
        end else if (hit_i) begin
            cap_o <= data_i;
        end
    end

    // R7: the capture holds between addressed slots.
    p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(cap_o));
endmodule

// File: rtl/slot_route_mux.sv
// Module: slot_route_mux
// Pure combinational selection of the two outgoing octets from the active
// mode. Assumes the match flags are already qualified by slot range.
module slot_route_mux
    import slot_loop_pkg::*;
#(
    parameter int          OCT_W     = 8,
    parameter logic [7:0]  AIS_OCTET = 8'hFF
) (
    input  lb_mode_e         mode_i,
    input  logic             alt_i,
    input  logic             hit_i,
    input  logic             slot0_copy_i,
    input  logic             is_slot0_i,
    input  logic [OCT_W-1:0] line_rx_i,
    input  logic [OCT_W-1:0] sys_tx_i,
    input  logic [OCT_W-1:0] idle_i,
    input  logic [OCT_W-1:0] regen_i,
    input  logic [OCT_W-1:0] cap_i,
    output logic [OCT_W-1:0] line_tx_o,
    output logic [OCT_W-1:0] sys_rx_o
);
    // Start from pass-through and override per mode.
    always_comb begin
        line_tx_o = sys_tx_i;
        sys_rx_o  = line_rx_i;
        unique case (mode_i)
            LB_NONE: ;
            LB_LINE, LB_FULL_LINE: line_tx_o = line_rx_i;
            LB_BOARD: begin
                line_tx_o = AIS_OCTET[OCT_W-1:0];
                sys_rx_o  = sys_tx_i;
            end
            LB_SYS_SLOT: if (hit_i) begin
                sys_rx_o  = sys_tx_i;
                line_tx_o = idle_i;
            end
            LB_LINE_SLOT: if (hit_i) begin
                line_tx_o = line_rx_i;
                sys_rx_o  = idle_i;
            end
            LB_BCAST: if (slot0_copy_i) line_tx_o = cap_i;
            LB_PAYLOAD: begin
                if (!alt_i) begin
                    line_tx_o = is_slot0_i ? regen_i : line_rx_i;
                end else if (slot0_copy_i) begin
                    sys_rx_o = cap_i;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/slot_loop_router.sv
// Module: slot_loop_router (top)
// Routes octets among line and system streams under a loopback control word.
// Assumes one octet per clock, slot_idx_i counting from 0 at frame_start_i.
// All outputs carry one register stage of latency.
module slot_loop_router
    import slot_loop_pkg::*;
#(
    parameter int         OCT_W        = 8,
    parameter int         SLOT_W       = 5,
    parameter int         SLOTS_WIDE   = 32,
    parameter int         SLOTS_NARROW = 24,
    parameter logic [7:0] AIS_OCTET    = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic [SLOT_W-1:0] slot_idx_i,
    input  logic              narrow_i,
    input  logic [SLOT_W+2:0] ctrl_i,
    input  logic              alt_sel_i,
    input  logic [OCT_W-1:0]  idle_code_i,
    input  logic [OCT_W-1:0]  regen_i,
    input  logic [OCT_W-1:0]  line_rx_i,
    input  logic [OCT_W-1:0]  sys_tx_i,
    output logic [OCT_W-1:0]  line_tx_o,
    output logic [OCT_W-1:0]  sys_rx_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic              frame_start_o
);
    localparam int LIM_W = SLOT_W + 1;
    localparam logic [LIM_W-1:0] LIM_WIDE   = LIM_W'(SLOTS_WIDE);
    localparam logic [LIM_W-1:0] LIM_NARROW = LIM_W'(SLOTS_NARROW);

    lb_mode_e          act_mode;
    logic [SLOT_W-1:0] act_addr;
    logic              act_alt;
    logic              addr_ok, hit, is_slot0, slot0_copy;
    logic [OCT_W-1:0]  cap, ltx_d, srx_d;

    slot_cfg_latch #(.SLOT_W(SLOT_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
        .ctrl_i(ctrl_i), .alt_sel_i(alt_sel_i),
        .mode_o(act_mode), .addr_o(act_addr), .alt_o(act_alt)
    );

    // Qualify the address against the frame length and find the slot matches.
    always_comb begin
        addr_ok    = {1'b0, act_addr} < (narrow_i ? LIM_NARROW : LIM_WIDE);
        hit        = addr_ok && (slot_idx_i == act_addr);
        is_slot0   = (slot_idx_i == '0);
        slot0_copy = addr_ok && is_slot0;
    end

    slot_capture #(.OCT_W(OCT_W)) i_cap (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .data_i(sys_tx_i), .cap_o(cap)
    );

    slot_route_mux #(.OCT_W(OCT_W), .AIS_OCTET(AIS_OCTET)) i_mux (
        .mode_i(act_mode), .alt_i(act_alt), .hit_i(hit),
        .slot0_copy_i(slot0_copy), .is_slot0_i(is_slot0),
        .line_rx_i(line_rx_i), .sys_tx_i(sys_tx_i), .idle_i(idle_code_i),
        .regen_i(regen_i), .cap_i(cap),
        .line_tx_o(ltx_d), .sys_rx_o(srx_d)
    );

    // Register every outgoing stream once to keep slot alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_tx_o     <= '0;
            sys_rx_o      <= '0;
            slot_idx_o    <= '0;
            frame_start_o <= 1'b0;
        end else begin
            line_tx_o     <= ltx_d;
            sys_rx_o      <= srx_d;
            slot_idx_o    <= slot_idx_i;
            frame_start_o <= frame_start_i;
        end
    end

    // R2: pass-through with one octet of latency.
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == LB_NONE) |=>
            (line_tx_o == $past(sys_tx_i) && sys_rx_o == $past(line_rx_i)));
    // R2: strobe alignment follows the data.
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> frame_start_o);
    // R3: full line loopback.
    p_line_loop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == LB_LINE || act_mode == LB_FULL_LINE) |=>
            (line_tx_o == $past(line_rx_i)));
    // R4: board loopback sends AIS to the line.
    p_board_ais_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == LB_BOARD) |=>
            (line_tx_o == AIS_OCTET[OCT_W-1:0] && sys_rx_o == $past(sys_tx_i)));
    // R11: out-of-range addresses never match in narrow frames.
    p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_i && act_addr >= SLOT_W'(SLOTS_NARROW)) |-> !hit);
endmodule

// File: tb/test_slot_loop_router.sv
module test_slot_loop_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start_i = 1'b0;
    logic [4:0] slot_idx_i = '0;
    logic       narrow_i = 1'b0;
    logic [7:0] ctrl_i = '0;
    logic       alt_sel_i = 1'b0;
    logic [7:0] idle_code_i = '0, regen_i = '0, line_rx_i = '0, sys_tx_i = '0;
    logic [7:0] line_tx_o, sys_rx_o;
    logic [4:0] slot_idx_o;
    logic       frame_start_o;

    always #10 clk = ~clk;

    slot_loop_router i_slot_loop_router (.*);

    int checks = 0, errors = 0;

    // Model state
    logic [2:0] m_mode = 3'd0;
    logic [4:0] m_addr = '0;
    logic       m_alt = 1'b0;
    logic [7:0] m_cap = '0;
    logic [7:0] e_ltx, e_srx;
    logic [4:0] e_idx;
    logic       e_fs;
    logic       e_valid = 1'b0;
    string      e_tag;

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // One octet: check the previous expectation, then drive and predict.
    task automatic tick(input logic fs, input logic [4:0] idx, input logic [7:0] ctrl, input logic alt);
        logic [7:0] lrx, stx, idl, rgn;
        logic       ok, hit;
        lrx = 8'($urandom); stx = 8'($urandom); idl = 8'($urandom); rgn = 8'($urandom);
        @(negedge clk);
        if (e_valid) begin
            chk(e_tag, "line_tx", line_tx_o, e_ltx);
            chk(e_tag, "sys_rx", sys_rx_o, e_srx);
            chk("R2", "slot_idx", {3'b0, slot_idx_o}, {3'b0, e_idx});
            chk("R2", "frame_start", {7'b0, frame_start_o}, {7'b0, e_fs});
        end
        frame_start_i = fs; slot_idx_i = idx; ctrl_i = ctrl; alt_sel_i = alt;
        line_rx_i = lrx; sys_tx_i = stx; idle_code_i = idl; regen_i = rgn;
        e_tag = "R2";
        if (!fs && (ctrl != {m_mode, m_addr} || alt != m_alt)) e_tag = "R10";
        if (fs) begin m_mode = ctrl[7:5]; m_addr = ctrl[4:0]; m_alt = alt; end
        ok  = {1'b0, m_addr} < (narrow_i ? 6'd24 : 6'd32);
        hit = ok && idx == m_addr;
        e_ltx = stx; e_srx = lrx;
        case (m_mode)
            3'd1, 3'd7: begin e_ltx = lrx; if (e_tag == "R2") e_tag = "R3"; end
            3'd2: begin e_ltx = 8'hFF; e_srx = stx; if (e_tag == "R2") e_tag = "R4"; end
            3'd3: if (hit) begin e_srx = stx; e_ltx = idl; e_tag = "R5_R12"; end
            3'd4: if (hit) begin e_ltx = lrx; e_srx = idl; e_tag = "R6_R12"; end
            3'd5: if (idx == 0 && ok) begin e_ltx = m_cap; e_tag = "R7"; end
            3'd6: if (!m_alt) begin
                      e_ltx = (idx == 0) ? rgn : lrx;
                      if (e_tag == "R2") e_tag = "R8";
                  end else if (idx == 0 && ok) begin
                      e_srx = m_cap; e_tag = "R9";
                  end
            default: ;
        endcase
        if (!ok && m_mode inside {3'd3, 3'd4, 3'd5, 3'd6} && e_tag == "R2") e_tag = "R11";
        if (hit) m_cap = stx;
        e_idx = idx; e_fs = fs; e_valid = 1'b1;
    endtask

    task automatic frame(input logic [7:0] ctrl, input logic alt, input logic jitter);
        int n;
        n = narrow_i ? 24 : 32;
        for (int s = 0; s < n; s++) begin
            if (s != 0 && jitter) tick(1'b0, 5'(s), 8'($urandom), 1'($urandom));
            else                  tick(s == 0, 5'(s), ctrl, alt);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        line_rx_i = 8'h5A; sys_tx_i = 8'hA5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears outputs
        chk("R1", "line_tx reset", line_tx_o, 8'h00);
        chk("R1", "sys_rx reset", sys_rx_o, 8'h00);
        chk("R1", "slot_idx reset", {3'b0, slot_idx_o}, 8'h00);
        chk("R1", "frame_start reset", {7'b0, frame_start_o}, 8'h00);
        rst_n = 1'b1;
        // R1: no loopback until a frame start accepts a word
        for (int s = 5; s < 12; s++) tick(1'b0, 5'(s), 8'h40, 1'b0);
        // Directed: every mode, wide and narrow, corner addresses
        for (int nw = 0; nw < 2; nw++) begin
            narrow_i = 1'(nw);
            for (int md = 0; md < 8; md++) begin
                frame({3'(md), 5'd0}, 1'b0, 1'b0);
                frame({3'(md), 5'd23}, 1'b1, 1'b0);
                frame({3'(md), 5'd23}, 1'b0, 1'b1);
                frame({3'(md), 5'd24}, 1'b1, 1'b0);
                frame({3'(md), 5'd31}, 1'b1, 1'b1);
            end
        end
        // Random frames with mid-frame control noise
        for (int f = 0; f < 150; f++) begin
            narrow_i = 1'($urandom);
            frame(8'($urandom), 1'($urandom), 1'($urandom));
        end
        tick(1'b0, 5'd0, {m_mode, m_addr}, m_alt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule